// File: doc/BRIEF.md
# Router Power Domain Gating Controller

This block decides, cycle by cycle, which of the separately switchable power domains of one mesh router are powered. The router has 5 ports with 4 virtual channels each. Its gated pieces are one buffer per input virtual channel, one crossbar multiplexer per output port, one virtual-channel multiplexer per output port and one output latch per port, which gives 35 domains. For every domain the controller drives a power-switch enable and a hold enable that clamps the domain's outputs while it is unpowered or not yet settled. It also reports whether the domain may accept a flit.

The router pipeline presents, for each domain, a flit-arrival pulse, a flit-departure pulse and an early-wakeup request. A domain that sees an arrival or a wakeup request while asleep powers up and waits a fixed number of cycles before it is ready. During that time, arrivals aimed at it stall upstream. A domain that is empty and idle steps through a one-cycle draining stage and then switches off. A global gating level selects which classes of domain may be gated at all, and a mask input forces individual domains to stay on. Two virtual channels on the processor-facing port are always kept on.

Top module: `pgc_router_ctrl`

## Requirements
- R1: While reset is high, every domain reads powered (pwr_en=1), unclamped (hold_en=0) and ready (ready=1). Domain indices are: input buffer of port p and virtual channel v at p*4+v; crossbar multiplexer of port p at 20+p; VC multiplexer at 25+p; output latch at 30+p.
- R2: An arrival or an early-wakeup request at a powered-off domain sets pwr_en in the following cycle. The domain then spends exactly WAKE_LAT cycles (default 3) with pwr_en=1, hold_en=1, ready=0, and becomes ready in the next cycle.
- R3: An early-wakeup request seen while a domain is waking or on does not restart the wakeup count and does not take the domain out of the ready state.
- R4: stall is high exactly when arrive is high and the domain is not ready. It is combinational in the current cycle.
- R5: An arrival accepted while ready increments the domain's flit count, and a departure decrements it. A domain holding at least one flit never leaves the ready state.
- R6: A ready domain with no stored flit and no arrival, departure or wakeup request in a cycle enters draining in the next cycle (pwr_en=1, hold_en=1, ready=0). If the next cycle also brings nothing, the domain is off one cycle later (pwr_en=0, hold_en=1).
- R7: An arrival or wakeup request while draining cancels the sleep, so the domain is ready again in the next cycle. That arrival still stalls.
- R8: hold_en is high in every cycle where ready is low. It is therefore high the cycle before pwr_en falls, and it stays high until the cycle after the wakeup count ends.
- R9: On the processor-facing port (LOCAL_PORT, default 4), the input buffers of virtual channels 0 and 2 (domains 16 and 18) never power down, whatever the gating level or mask.
- R10: gate_level selects the gated classes. 0 gates nothing. 1 gates input buffers only. 2 adds crossbar and VC multiplexers. 3 adds output latches. An ungated domain that is off wakes through the normal latency and then stays ready.
- R11: A set bit in aon_mask keeps that domain powered in the same way as an ungated class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_level | input | 2 | Which domain classes may be gated (0 to 3) |
| aon_mask | input | 35 | Per-domain force-on mask |
| arrive | input | 35 | Flit targeting each domain this cycle |
| depart | input | 35 | Flit leaving each domain this cycle |
| wake_req | input | 35 | Early wakeup request per domain |
| pwr_en | output | 35 | Power-switch enable per domain |
| hold_en | output | 35 | Output clamp enable per domain |
| ready | output | 35 | Domain is on and may take a flit |
| stall | output | 35 | Arrival must be held upstream |

## Verification
The embedded properties check several rules on every cycle. The clamp must be raised before power drops. The wakeup counter must advance by one each waking cycle, even when wakeup requests repeat. A domain with stored flits, or one that is forced on, must never leave the ready state. A draining domain hit by an arrival must return to ready. The exact wakeup length, the draining-then-off sequence, the decoding of each gating level and the fixed always-on channels depend on chosen stimulus and absolute cycle counts. Only the bench's scenarios can show those, by comparing each domain's outputs with expectations scheduled for specific cycles.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        PD_OFF    = 2'd0,
        PD_WAKING = 2'd1,
        PD_ON     = 2'd2,
        PD_DRAIN  = 2'd3
    } pd_state_e;

    typedef enum logic [1:0] {
        CLS_INBUF  = 2'd0,
        CLS_XBAR   = 2'd1,
        CLS_VCMUX  = 2'd2,
        CLS_OUTLAT = 2'd3
    } pd_class_e;

    typedef struct packed {
        logic arrive;
        logic depart;
        logic wake;
    } pd_evt_t;

    // Class of a domain from its flat index.
    function automatic pd_class_e dom_class(input int idx, input int nport, input int nvc);
        if (idx < nport * nvc)
            return CLS_INBUF;
        else if (idx < nport * nvc + nport)
            return CLS_XBAR;
        else if (idx < nport * nvc + 2 * nport)
            return CLS_VCMUX;
        else
            return CLS_OUTLAT;
    endfunction

    // True when the gating level allows this class to be switched off.
    function automatic logic level_gates(input pd_class_e cls, input logic [1:0] lvl);
        case (cls)
            CLS_INBUF:  return lvl != 2'd0;
            CLS_XBAR,
            CLS_VCMUX:  return lvl >= 2'd2;
            default:    return lvl == 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/pgc_policy.sv
module pgc_policy
    import pgc_pkg::*;
#(
    parameter int NPORT       = 5,
    parameter int NVC         = 4,
    parameter int LOCAL_PORT  = 4,
    parameter logic [NVC-1:0] CPU_AON_VCS = 4'b0101,
    localparam int ND         = NPORT * NVC + 3 * NPORT
) (
    input  logic [1:0]    gate_level,
    input  logic [ND-1:0] aon_mask,
    output logic [ND-1:0] keep
);

    for (genvar d = 0; d < ND; d++) begin : g_dom
        localparam pd_class_e CLS = dom_class(d, NPORT, NVC);
        localparam bit FIXED_ON = (d < NPORT * NVC) &&
                                  ((d / NVC) == LOCAL_PORT) &&
                                  CPU_AON_VCS[d % NVC];
        assign keep[d] = aon_mask[d] | FIXED_ON | ~level_gates(CLS, gate_level);
    end

endmodule

// File: rtl/pgc_domain.sv
module pgc_domain
    import pgc_pkg::*;
#(
    parameter int WAKE_LAT = 3,
    parameter int OCC_W    = 3,
    localparam int CNT_W   = (WAKE_LAT > 1) ? $clog2(WAKE_LAT) : 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    keep,
    input  pd_evt_t evt,
    output logic    pwr_en,
    output logic    hold_en,
    output logic    ready
);

    localparam logic [OCC_W-1:0] OCC_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_LAT - 1);

    pd_state_e        state, state_n;
    logic [CNT_W-1:0] cnt;
    logic [OCC_W-1:0] occ;
    logic             acc, dep, idle, wake_evt;

    assign acc      = evt.arrive & (state == PD_ON);
    assign dep      = evt.depart & (occ != '0);
    assign idle     = ~evt.arrive & ~evt.depart & ~evt.wake;
    assign wake_evt = evt.arrive | evt.wake | keep;

    always_comb begin
        state_n = state;
        case (state)
            PD_OFF:    if (wake_evt) state_n = PD_WAKING;
            PD_WAKING: if (cnt == CNT_LAST) state_n = PD_ON;
            PD_ON:     if (!keep && occ == '0 && idle) state_n = PD_DRAIN;
            PD_DRAIN:  state_n = wake_evt ? PD_ON : PD_OFF;
            default:   state_n = PD_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PD_ON;
            cnt   <= '0;
            occ   <= '0;
        end else begin
            state <= state_n;
            cnt   <= (state == PD_WAKING) ? cnt + 1'b1 : '0;
            if (acc && !dep && occ != OCC_MAX)
                occ <= occ + 1'b1;
            else if (dep && !acc)
                occ <= occ - 1'b1;
        end
    end

    assign pwr_en  = (state != PD_OFF);
    assign hold_en = (state != PD_ON);
    assign ready   = (state == PD_ON);

    // R8
    hold_before_cut_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en) |-> $past(hold_en));

    // R3
    wake_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PD_WAKING && cnt != CNT_LAST) |=>
        (state == PD_WAKING && cnt == CNT_W'($past(cnt) + 1'b1)));

    // R2
    wake_from_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwr_en && evt.arrive) |=> (pwr_en && !ready));

    // R5
    occupied_stays_on_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && occ != '0) |=> ready);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc && !dep && occ == OCC_MAX));

    // R7
    drain_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PD_DRAIN && evt.arrive) |=> ready);

    // R11
    keep_on_chk: assert property (@(posedge clk) disable iff (rst)
        (keep && ready) |=> ready);

endmodule

// File: rtl/pgc_router_ctrl.sv
module pgc_router_ctrl
    import pgc_pkg::*;
#(
    parameter int NPORT       = 5,
    parameter int NVC         = 4,
    parameter int LOCAL_PORT  = 4,
    parameter logic [NVC-1:0] CPU_AON_VCS = 4'b0101,
    parameter int WAKE_LAT    = 3,
    parameter int OCC_W       = 3,
    localparam int ND         = NPORT * NVC + 3 * NPORT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    gate_level,
    input  logic [ND-1:0] aon_mask,
    input  logic [ND-1:0] arrive,
    input  logic [ND-1:0] depart,
    input  logic [ND-1:0] wake_req,
    output logic [ND-1:0] pwr_en,
    output logic [ND-1:0] hold_en,
    output logic [ND-1:0] ready,
    output logic [ND-1:0] stall
);

    logic [ND-1:0] keep;

    pgc_policy #(
        .NPORT       (NPORT),
        .NVC         (NVC),
        .LOCAL_PORT  (LOCAL_PORT),
        .CPU_AON_VCS (CPU_AON_VCS)
    ) u_policy (
        .gate_level (gate_level),
        .aon_mask   (aon_mask),
        .keep       (keep)
    );

    for (genvar d = 0; d < ND; d++) begin : g_dom
        pd_evt_t evt;
        assign evt = '{arrive: arrive[d], depart: depart[d], wake: wake_req[d]};

        pgc_domain #(
            .WAKE_LAT (WAKE_LAT),
            .OCC_W    (OCC_W)
        ) u_dom (
            .clk     (clk),
            .rst     (rst),
            .keep    (keep[d]),
            .evt     (evt),
            .pwr_en  (pwr_en[d]),
            .hold_en (hold_en[d]),
            .ready   (ready[d])
        );
    end

    assign stall = arrive & ~ready;

    // R9
    cpu_vc_on_chk: assert property (@(posedge clk) disable iff (rst)
        (ready[LOCAL_PORT*NVC] && ready[LOCAL_PORT*NVC+2]) |=>
        (ready[LOCAL_PORT*NVC] && ready[LOCAL_PORT*NVC+2]));

endmodule

// File: tb/pgc_router_ctrl_tb.sv
module pgc_router_ctrl_tb;

    localparam int ND = 35;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    gate_level;
    logic [ND-1:0] aon_mask, arrive, depart, wake_req;
    logic [ND-1:0] pwr_en, hold_en, ready, stall;

    always #5 clk = ~clk;

    pgc_router_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .gate_level (gate_level),
        .aon_mask   (aon_mask),
        .arrive     (arrive),
        .depart     (depart),
        .wake_req   (wake_req),
        .pwr_en     (pwr_en),
        .hold_en    (hold_en),
        .ready      (ready),
        .stall      (stall)
    );

    typedef struct {
        int    at;
        int    dom;
        logic  [2:0] vec;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc    = 0;
    int   checks = 0;
    int   errors = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // expected {pwr_en, hold_en, ready} of a domain in a given cycle
    task automatic push(input int at, input int dom, input logic [2:0] v, input string tag);
        exp_t e;
        e.at = at; e.dom = dom; e.vec = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: compare scheduled expectations
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                logic [2:0] act;
                act = {pwr_en[sb[i].dom], hold_en[sb[i].dom], ready[sb[i].dom]};
                checks++;
                if (act !== sb[i].vec) begin
                    errors++;
                    $display("FAIL %s dom=%0d cyc=%0d actual=%b expected=%b",
                             sb[i].tag, sb[i].dom, cyc, act, sb[i].vec);
                end
                sb.delete(i);
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    localparam logic [2:0] V_ON    = 3'b101;
    localparam logic [2:0] V_TRANS = 3'b110;
    localparam logic [2:0] V_OFF   = 3'b010;

    initial begin
        int n;
        rst = 1'b1; gate_level = 2'd3;
        aon_mask = '0; arrive = '0; depart = '0; wake_req = '0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check(pwr_en === '1, "R1 pwr_en", 0, 1);
        check(hold_en === '0, "R1 hold_en", 1, 0);
        check(ready === '1, "R1 ready", 0, 1);

        n = cyc; rst = 1'b0;
        push(n + 1, 0, V_TRANS, "R6 drain after reset");
        push(n + 2, 0, V_OFF, "R6 off after reset");
        push(n + 2, 16, V_ON, "R9 cpu vc0");
        push(n + 2, 18, V_ON, "R9 cpu vc2");
        push(n + 2, 17, V_OFF, "R9 cpu vc1 gated");
        push(n + 2, 34, V_OFF, "R10 outlat gated lvl3");
        repeat (3) @(negedge clk);

        // wake, wake-restart, occupancy, drain cancel
        n = cyc;
        arrive[1] = 1'b1; wake_req[2] = 1'b1; wake_req[3] = 1'b1; wake_req[5] = 1'b1;
        #1 check(stall[1] === 1'b1, "R4 stall when off", stall[1], 1);
        for (int k = 1; k <= 3; k++) begin
            push(n + k, 1, V_TRANS, "R2 waking");
            push(n + k, 2, V_TRANS, "R8 hold while waking");
        end
        push(n + 4, 1, V_ON, "R2 ready after latency");
        push(n + 5, 1, V_TRANS, "R6 drain");
        push(n + 6, 1, V_OFF, "R6 off");
        push(n + 4, 2, V_ON, "R3 no restart");
        push(n + 5, 2, V_ON, "R3 wake in on");
        push(n + 6, 2, V_TRANS, "R6 drain after wake");
        for (int k = 5; k <= 9; k++) push(n + k, 3, V_ON, "R5 occupied");
        push(n + 10, 3, V_TRANS, "R6 drain after depart");
        push(n + 11, 3, V_OFF, "R6 off after depart");
        push(n + 5, 5, V_TRANS, "R6 drain");
        push(n + 6, 5, V_ON, "R7 cancel");
        push(n + 7, 5, V_TRANS, "R7 redrain");
        push(n + 8, 5, V_OFF, "R7 off");
        @(negedge clk);
        arrive[1] = 1'b0; wake_req[3] = 1'b0; wake_req[5] = 1'b0;
        @(negedge clk);
        wake_req[2] = 1'b0;
        repeat (2) @(negedge clk);
        wake_req[2] = 1'b1; arrive[3] = 1'b1;
        #1 check(stall[3] === 1'b0, "R4 no stall when ready", stall[3], 0);
        @(negedge clk);
        wake_req[2] = 1'b0; arrive[3] = 1'b0; arrive[5] = 1'b1;
        #1 check(stall[5] === 1'b1, "R7 stall while draining", stall[5], 1);
        @(negedge clk);
        arrive[5] = 1'b0;
        repeat (2) @(negedge clk);
        depart[3] = 1'b1;
        @(negedge clk);
        depart[3] = 1'b0;
        repeat (4) @(negedge clk);

        // gating levels
        n = cyc; gate_level = 2'd1;
        push(n + 3, 20, V_TRANS, "R10 xbar waking");
        push(n + 4, 20, V_ON, "R10 lvl1 xbar on");
        push(n + 4, 25, V_ON, "R10 lvl1 vcmux on");
        push(n + 4, 30, V_ON, "R10 lvl1 outlat on");
        push(n + 4, 0, V_OFF, "R10 lvl1 inbuf gated");
        repeat (5) @(negedge clk);
        n = cyc; gate_level = 2'd2;
        push(n + 2, 20, V_OFF, "R10 lvl2 xbar gated");
        push(n + 2, 25, V_OFF, "R10 lvl2 vcmux gated");
        push(n + 2, 30, V_ON, "R10 lvl2 outlat on");
        repeat (3) @(negedge clk);
        n = cyc; gate_level = 2'd0;
        push(n + 4, 0, V_ON, "R10 lvl0 inbuf on");
        push(n + 4, 20, V_ON, "R10 lvl0 xbar on");
        repeat (5) @(negedge clk);
        n = cyc; gate_level = 2'd3;
        push(n + 2, 0, V_OFF, "R10 lvl3 inbuf off");
        push(n + 2, 30, V_OFF, "R10 lvl3 outlat off");
        push(n + 2, 16, V_ON, "R9 cpu vc0 lvl3");
        push(n + 2, 18, V_ON, "R9 cpu vc2 lvl3");
        repeat (3) @(negedge clk);

        // aon mask
        n = cyc; aon_mask[7] = 1'b1;
        push(n + 4, 7, V_ON, "R11 mask wakes");
        push(n + 10, 7, V_ON, "R11 mask holds on");
        push(n + 4, 6, V_OFF, "R11 neighbour off");
        repeat (12) @(negedge clk);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
        end
        finish_run();
    end

endmodule